// File: doc/BRIEF.md
# Status Flags Register Unit

This block keeps the four arithmetic status flags of a small processor: carry, zero, sign and overflow. Each cycle in which the write enable is high, it looks at the operation class, the two operands and the result the datapath produced. It then recomputes the flags that this class affects and keeps the others as they were. The new values appear one clock later, both as four separate bits and as a packed 4-bit word.

The operand width can be chosen per operation as 8, 16 or 32 bits. Every flag is evaluated only over the low bits of the chosen width, so bits above that width have no effect.

The block does not produce the result itself. It relies on the datapath to supply a result that matches the operands: the sum for add, the difference for subtract, the first operand plus one for increment.

Top module: `status_flag_unit`

## Requirements
- R1: A synchronous active-high reset clears all four flags and the packed word to 0.
- R2: While `wr_en` is low, no flag changes, whatever the other inputs do.
- R3: A move (`op_cls` = 3) written with `wr_en` high leaves every flag unchanged, even when the moved value is zero.
- R4: After an add (0), subtract (1) or increment (2), zero is 1 exactly when the result is all zeros over the selected width. Subtracting two equal values sets it, and incrementing 0 to 1 clears it.
- R5: After an add, subtract or increment, sign equals the top bit of the result at the selected width.
- R6: After an add, carry is 1 exactly when the unsigned sum of the two operands, taken at the selected width, does not fit in that width.
- R7: After a subtract, carry is 1 exactly when the first operand is smaller than the second, compared unsigned at the selected width.
- R8: After an add, overflow is 1 when the operands have the same sign and the result's sign differs from it. After a subtract, overflow is 1 when the operands differ in sign and the result's sign differs from the first operand's sign.
- R9: An increment updates overflow, sign and zero, and leaves carry unchanged. Overflow is set when the operand is the largest positive value at the selected width.
- R10: `width_sel` = 0 selects 8 bits, 1 selects 16 bits, and 2 or 3 select 32 bits. Operand and result bits above the selected width do not affect any flag.
- R11: `flags_word` carries carry in bit 0, zero in bit 1, sign in bit 2 and overflow in bit 3, always equal to the single flag outputs.
- R12: Flags written at a clock edge where `wr_en` is high become visible right after that edge, and not before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Update the flags for the current operation |
| op_cls | input | 2 | Operation class: 0 add, 1 subtract, 2 increment, 3 move |
| width_sel | input | 2 | Operand width: 0 is 8 bits, 1 is 16 bits, 2 or 3 is 32 bits |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand (ignored for increment and move) |
| result | input | 32 | Result produced by the datapath |
| flag_c | output | 1 | Carry / borrow flag |
| flag_z | output | 1 | Zero flag |
| flag_s | output | 1 | Sign flag |
| flag_v | output | 1 | Overflow flag |
| flags_word | output | 4 | Packed flags {V, S, Z, C} |

## Verification
The embedded assertions check four rules on every cycle. Idle cycles and moves leave the flags stable. An increment never touches carry. Subtracting two equal 32-bit values with a zero result always leaves zero set, and a 32-bit subtract with an unsigned borrow always leaves carry set.

Only the bench's scenarios can show that the flag values are correct. That means carry and overflow at each of the three widths, the masking of upper bits, the packed word's bit order, the cycle at which the flags appear, and clearing by reset partway through a run.

// File: rtl/sfu_pkg.sv
package sfu_pkg;

  typedef enum logic [1:0] {
    OP_ADD  = 2'd0,
    OP_SUB  = 2'd1,
    OP_INC  = 2'd2,
    OP_MOVE = 2'd3
  } op_class_e;

  localparam int FLAG_N = 4;
  // bit positions inside the packed flags word
  localparam int FB_C = 0;
  localparam int FB_Z = 1;
  localparam int FB_S = 2;
  localparam int FB_V = 3;

endpackage

// File: rtl/sfu_width_sel.sv
// Turns the width select into a lane mask, a one-hot mark of the sign bit,
// and a one-hot mark of the carry-out position (one above the top bit).
module sfu_width_sel #(
  parameter int DATA_W   = 32,
  parameter int NARROW_W = 8,
  parameter int MID_W    = 16
) (
  input  logic [1:0]        width_sel,
  output logic [DATA_W-1:0] lane_mask,
  output logic [DATA_W-1:0] msb_oh,
  output logic [DATA_W:0]   cout_oh
);

  localparam logic [DATA_W-1:0] MASK_NARROW = {{(DATA_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};
  localparam logic [DATA_W-1:0] MASK_MID    = {{(DATA_W-MID_W){1'b0}}, {MID_W{1'b1}}};
  localparam logic [DATA_W-1:0] MASK_FULL   = {DATA_W{1'b1}};

  always_comb begin
    case (width_sel)
      2'd0:    lane_mask = MASK_NARROW;
      2'd1:    lane_mask = MASK_MID;
      default: lane_mask = MASK_FULL;
    endcase
  end

  assign msb_oh  = lane_mask ^ (lane_mask >> 1);
  assign cout_oh = {1'b0, lane_mask} + {{DATA_W{1'b0}}, 1'b1};

endmodule

// File: rtl/sfu_flag_calc.sv
// Computes candidate flag values from operands and result at the chosen width.
module sfu_flag_calc
  import sfu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  op_class_e         op,
  input  logic [DATA_W-1:0] lane_mask,
  input  logic [DATA_W-1:0] msb_oh,
  input  logic [DATA_W:0]   cout_oh,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic [DATA_W-1:0] result,
  output logic [FLAG_N-1:0] cand
);

  logic [DATA_W-1:0] a_m, b_m, r_m;
  logic [DATA_W:0]   sum_ext;
  logic              sgn_a, sgn_b, sgn_r;
  logic              add_carry, sub_borrow;

  assign a_m = opnd_a & lane_mask;
  assign b_m = opnd_b & lane_mask;
  assign r_m = result & lane_mask;

  assign sgn_a = |(opnd_a & msb_oh);
  assign sgn_b = |(opnd_b & msb_oh);
  assign sgn_r = |(result & msb_oh);

  assign sum_ext    = {1'b0, a_m} + {1'b0, b_m};
  assign add_carry  = |(sum_ext & cout_oh);
  assign sub_borrow = a_m < b_m;

  always_comb begin
    cand       = '0;
    cand[FB_Z] = (r_m == '0);
    cand[FB_S] = sgn_r;
    case (op)
      OP_ADD: begin
        cand[FB_C] = add_carry;
        cand[FB_V] = (sgn_a == sgn_b) && (sgn_r != sgn_a);
      end
      OP_SUB: begin
        cand[FB_C] = sub_borrow;
        cand[FB_V] = (sgn_a != sgn_b) && (sgn_r != sgn_a);
      end
      OP_INC: begin
        cand[FB_C] = 1'b0;
        cand[FB_V] = !sgn_a && sgn_r;
      end
      default: begin
        cand[FB_C] = 1'b0;
        cand[FB_V] = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/sfu_update_sel.sv
// Per operation class, which flags take the new value.
module sfu_update_sel
  import sfu_pkg::*;
(
  input  logic              wr_en,
  input  op_class_e         op,
  output logic [FLAG_N-1:0] upd
);

  logic [FLAG_N-1:0] cls_mask;

  always_comb begin
    case (op)
      OP_ADD, OP_SUB: cls_mask = '1;
      OP_INC: begin
        cls_mask       = '1;
        cls_mask[FB_C] = 1'b0;
      end
      default: cls_mask = '0;
    endcase
  end

  assign upd = wr_en ? cls_mask : '0;

endmodule

// File: rtl/status_flag_unit.sv
module status_flag_unit
  import sfu_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int NARROW_W = 8,
  parameter int MID_W    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        op_cls,
  input  logic [1:0]        width_sel,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic [DATA_W-1:0] result,
  output logic              flag_c,
  output logic              flag_z,
  output logic              flag_s,
  output logic              flag_v,
  output logic [FLAG_N-1:0] flags_word
);

  op_class_e         op;
  logic [DATA_W-1:0] lane_mask, msb_oh;
  logic [DATA_W:0]   cout_oh;
  logic [FLAG_N-1:0] cand, upd, flag_q;

  assign op = op_class_e'(op_cls);

  sfu_width_sel #(.DATA_W(DATA_W), .NARROW_W(NARROW_W), .MID_W(MID_W)) u_wsel (
    .width_sel (width_sel),
    .lane_mask (lane_mask),
    .msb_oh    (msb_oh),
    .cout_oh   (cout_oh)
  );

  sfu_flag_calc #(.DATA_W(DATA_W)) u_calc (
    .op        (op),
    .lane_mask (lane_mask),
    .msb_oh    (msb_oh),
    .cout_oh   (cout_oh),
    .opnd_a    (opnd_a),
    .opnd_b    (opnd_b),
    .result    (result),
    .cand      (cand)
  );

  sfu_update_sel u_upd (
    .wr_en (wr_en),
    .op    (op),
    .upd   (upd)
  );

  for (genvar i = 0; i < FLAG_N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)         flag_q[i] <= 1'b0;
      else if (upd[i]) flag_q[i] <= cand[i];
    end
  end

  assign flags_word = flag_q;
  assign flag_c     = flag_q[FB_C];
  assign flag_z     = flag_q[FB_Z];
  assign flag_s     = flag_q[FB_S];
  assign flag_v     = flag_q[FB_V];

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(flags_word));

  assert_move_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && op_cls == 2'd3) |=> $stable(flags_word));

  assert_inc_keeps_carry_R9: assert property (@(posedge clk) disable iff (rst)
    (wr_en && op_cls == 2'd2) |=> $stable(flag_c));

  assert_sub_equal_zero_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && op_cls == 2'd1 && width_sel[1] && opnd_a == opnd_b && result == '0)
    |=> flag_z);

  assert_sub_borrow_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && op_cls == 2'd1 && width_sel[1] && opnd_a < opnd_b) |=> flag_c);

endmodule

// File: tb/sim_status_flag_unit.sv
module sim_status_flag_unit;

  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en;
  logic [1:0]  op_cls, width_sel;
  logic [31:0] opnd_a, opnd_b, result;
  logic        flag_c, flag_z, flag_s, flag_v;
  logic [3:0]  flags_word;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  status_flag_unit u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .op_cls(op_cls), .width_sel(width_sel),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .result(result),
    .flag_c(flag_c), .flag_z(flag_z), .flag_s(flag_s), .flag_v(flag_v),
    .flags_word(flags_word)
  );

  typedef struct packed {
    logic [1:0]  op;
    logic [1:0]  ws;
    logic [31:0] a;
    logic [31:0] b;
    logic [3:0]  exp;   // {V,S,Z,C}
  } vec_t;

  localparam int NV = 14;
  localparam vec_t TBL [NV] = '{
    '{2'd0, 2'd0, 32'h0000_007F, 32'h0000_0001, 4'b1100}, // R8 R5 add overflow 8b
    '{2'd0, 2'd0, 32'h0000_00FF, 32'h0000_0001, 4'b0011}, // R6 R4 add carry, zero 8b
    '{2'd3, 2'd0, 32'h0000_0000, 32'h0000_0000, 4'b0011}, // R3 move of zero keeps all
    '{2'd1, 2'd0, 32'h0000_0055, 32'h0000_0055, 4'b0010}, // R4 equal subtract sets zero
    '{2'd2, 2'd1, 32'h0000_0000, 32'h0000_0000, 4'b0000}, // R4 R9 inc 0->1 clears zero
    '{2'd1, 2'd1, 32'h0000_0000, 32'h0000_0001, 4'b0101}, // R7 R5 borrow 16b
    '{2'd2, 2'd1, 32'h0000_7FFF, 32'h0000_0000, 4'b1101}, // R9 inc overflow, carry kept 1
    '{2'd3, 2'd1, 32'h1234_0000, 32'h0000_0000, 4'b1101}, // R3 move keeps all
    '{2'd0, 2'd2, 32'h8000_0000, 32'h8000_0000, 4'b1011}, // R6 R8 add 32b carry+overflow
    '{2'd1, 2'd2, 32'h8000_0000, 32'h0000_0001, 4'b1000}, // R8 sub overflow 32b
    '{2'd0, 2'd0, 32'hABCD_0010, 32'h1234_0020, 4'b0000}, // R10 upper bits ignored
    '{2'd1, 2'd0, 32'h1234_5680, 32'h0000_0080, 4'b0010}, // R10 R4 zero at 8b only
    '{2'd2, 2'd2, 32'hFFFF_FFFF, 32'h0000_0000, 4'b0010}, // R9 inc wrap, carry kept 0
    '{2'd0, 2'd3, 32'h7FFF_FFFF, 32'h0000_0001, 4'b1100}  // R10 sel 3 acts as 32b
  };

  function automatic logic [31:0] calc_res(logic [1:0] op, logic [31:0] a, logic [31:0] b);
    case (op)
      2'd0:    return a + b;
      2'd1:    return a - b;
      2'd2:    return a + 32'd1;
      default: return a;
    endcase
  endfunction

  task automatic check(string req, logic [3:0] got, logic [3:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", req, got, exp);
    end
  endtask

  task automatic drive(logic we, logic [1:0] op, logic [1:0] ws, logic [31:0] a, logic [31:0] b);
    wr_en = we; op_cls = op; width_sel = ws;
    opnd_a = a; opnd_b = b; result = calc_res(op, a, b);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    rst = 1'b1;
    drive(1'b0, 2'd0, 2'd0, '0, '0);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset word", flags_word, 4'b0000);

    // table walk
    for (int i = 0; i < NV; i++) begin
      drive(1'b1, TBL[i].op, TBL[i].ws, TBL[i].a, TBL[i].b);
      @(negedge clk);
      check($sformatf("table vector %0d", i), flags_word, TBL[i].exp);
      wr_en = 1'b0;
    end

    // R11: single flags agree with packed word layout {V,S,Z,C}; last state 1100
    check("R11 bit order", {flag_v, flag_s, flag_z, flag_c}, 4'b1100);

    // R2: disabled write with a zero-producing subtract leaves flags alone
    drive(1'b0, 2'd1, 2'd2, 32'h5, 32'h5);
    repeat (2) @(negedge clk);
    check("R2 idle hold", flags_word, 4'b1100);

    // R12: nothing visible before the edge, visible right after it
    @(negedge clk);
    drive(1'b1, 2'd1, 2'd2, 32'h5, 32'h5);
    #1;
    check("R12 before edge", flags_word, 4'b1100);
    @(negedge clk);
    check("R12 after edge", flags_word, 4'b0010);
    wr_en = 1'b0;

    // R6: 16-bit add carry out with upper bits ignored
    drive(1'b1, 2'd0, 2'd1, 32'h0000_8000, 32'h0001_8000);
    @(negedge clk);
    check("R6 add carry 16b", flags_word, 4'b1011);
    wr_en = 1'b0;

    // R7: no borrow when first operand larger at 8b though smaller at 32b
    drive(1'b1, 2'd1, 2'd0, 32'h0000_0090, 32'h0000_0110);
    @(negedge clk);
    check("R7 no borrow 8b", flags_word, 4'b0100);
    wr_en = 1'b0;

    // R1: reset during operation clears everything
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1 mid-run reset", flags_word, 4'b0000);

    done = 1'b1;
    finish_run();
  end

endmodule